// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block lets a clocked requester on the chip read and write an external asynchronous static RAM of 32K bytes. A request is a single-cycle valid with a direction flag, a 15-bit address and, for writes, a byte of data. The request is taken only while `req_ready` is high. The block then runs the active-low chip-enable, write-enable and output-enable strobes of the memory through a fixed sequence. For a read it returns the byte with a one-cycle `rsp_valid` strobe. The data bus of the memory is split into an output byte, an output-enable and an input byte, so the pad ring can build the tri-state buffer.

Every wait is given as a nanosecond figure: access time, write pulse width, data setup and bus release time. The controller turns each figure into a whole number of clock cycles for the configured clock period, rounding up. A write is the overlap of chip enable and write enable. The data is driven before write enable falls and stays unchanged until one cycle after write enable rises. Output enable stays high for the whole write. After every read there are idle cycles with all strobes high, so the memory has released the bus before the controller can drive it again.

Top module: `asr_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: A read runs for RD = ceil(ACCESS_NS / CLK_PERIOD_NS) cycles after the accepting edge. During these cycles `mem_ce_n` and `mem_oe_n` are 0, `mem_we_n` is 1 and `mem_addr` holds the request address. On the edge that ends them, all strobes return high.
- R3: A write has three phases after the accepting edge. First come SU = max(1, ceil(DATA_SETUP_NS / CLK_PERIOD_NS) - PW) cycles with `mem_ce_n` 0, `mem_dq_oe` 1 and `mem_we_n` 1. Then come PW = ceil(WE_PULSE_NS / CLK_PERIOD_NS) cycles with `mem_we_n` 0. Last comes one cycle with `mem_we_n` 1 while `mem_ce_n` stays 0 and `mem_dq_oe` stays 1. After that, `mem_ce_n` is 1 and `mem_dq_oe` is 0.
- R4: `mem_oe_n` is 1 on every write cycle. `mem_dq_oe` is never 1 while the memory is driving its pins (chip enable low, output enable low, write enable high).
- R5: `mem_addr` and `mem_dq_out` do not change from the cycle before write enable falls until the cycle after it rises. The byte stored by the memory is the request byte.
- R6: `req_ready` is 0 from the accepting edge until the operation ends. A `req_valid` seen while `req_ready` is 0 changes no output and writes nothing.
- R7: After the read strobes rise, `req_ready` returns to 1 only after TA = ceil(BUS_RELEASE_NS / CLK_PERIOD_NS) cycles, and all strobes stay high during these cycles.
- R8: `rsp_valid` is 1 for exactly one cycle per read: the cycle right after the RD cycles. It never rises for a write. `rsp_rdata` then holds the byte the memory drove.
- R9: A read returns the last byte written to that address, including addresses 0x0000 and 0x7FFF.
- R10: A request presented on the first cycle `req_ready` is 1 again is accepted at once. Reads and writes can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted when high together with valid |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Byte to drive onto the memory data pins |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_dq_in | input | 8 | Byte seen on the memory data pins |

## Verification
Every output of the block is a register, so each result can be placed on a fixed cycle after the accepting edge:
- The strobes of a read change on that edge.
- `rsp_valid` and its byte appear RD cycles later.
- `req_ready` rises RD + TA cycles after that edge.
- `mem_we_n` falls SU cycles after a write is taken.
- `mem_we_n` rises after PW more cycles.
- The bus is released one cycle after `mem_we_n` rises.

The bench drives with a clock period parameter that makes RD, PW and TA larger than one. It keeps a counter of cycles since acceptance and, at every falling clock edge, compares every pin against the value that counter predicts. Its memory model works on the same falling edges. It flags any change of address or data while a write is open, and any cycle in which both sides drive the data pins.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD      = 3'd1,
    ST_RECOVER = 3'd2,
    ST_WSETUP  = 3'd3,
    ST_WPULSE  = 3'd4,
    ST_WHOLD   = 3'd5
  } asr_state_e;

  // whole cycles needed to cover ns, at least one
  function automatic int cyc_ceil(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asr_timer.sv
module asr_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asr_seq.sv
module asr_seq
  import asr_pkg::*;
#(
  parameter int RD_C  = 1,
  parameter int WS_C  = 1,
  parameter int WP_C  = 1,
  parameter int TA_C  = 1,
  parameter int CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             cap_en,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             ready
);
  asr_state_e state_q;

  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] WS_LD = CNT_W'(WS_C - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_C - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_C - 1);

  always_comb begin
    accept   = req_valid && ready && (state_q == ST_IDLE);
    cap_en   = (state_q == ST_RD) && tmr_done;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = req_write ? WS_LD : RD_LD;
      end
      ST_RD: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = TA_LD;
      end
      ST_WSETUP: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      ready   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ready <= 1'b0;
          ce_n  <= 1'b0;
          if (req_write) begin
            dq_oe   <= 1'b1;
            state_q <= ST_WSETUP;
          end else begin
            oe_n    <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: if (tmr_done) begin
          ce_n    <= 1'b1;
          oe_n    <= 1'b1;
          state_q <= ST_RECOVER;
        end
        ST_RECOVER: if (tmr_done) begin
          ready   <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_WSETUP: if (tmr_done) begin
          we_n    <= 1'b0;
          state_q <= ST_WPULSE;
        end
        ST_WPULSE: if (tmr_done) begin
          we_n    <= 1'b1;
          state_q <= ST_WHOLD;
        end
        ST_WHOLD: begin
          ce_n    <= 1'b1;
          dq_oe   <= 1'b0;
          ready   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RD_STROBES: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !ce_n && !dq_oe)); // R2
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && oe_n && dq_oe)); // R3
  AST_RECOVER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECOVER) |-> (ce_n && oe_n && we_n && !dq_oe && !ready)); // R7

endmodule

// File: rtl/asr_pins.sv
module asr_pins #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      if (req_write) mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/asr_ctrl.sv
module asr_ctrl
  import asr_pkg::*;
#(
  parameter int ADDR_W         = 15,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_NS  = 20,
  parameter int ACCESS_NS      = 12,
  parameter int WE_PULSE_NS    = 8,
  parameter int DATA_SETUP_NS  = 7,
  parameter int BUS_RELEASE_NS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_C  = cyc_ceil(ACCESS_NS, CLK_PERIOD_NS);
  localparam int WP_C  = cyc_ceil(WE_PULSE_NS, CLK_PERIOD_NS);
  localparam int WS_C  = max_int(1, cyc_ceil(DATA_SETUP_NS, CLK_PERIOD_NS) - WP_C);
  localparam int TA_C  = cyc_ceil(BUS_RELEASE_NS, CLK_PERIOD_NS);
  localparam int MAX_C = max_int(max_int(RD_C, WP_C), max_int(WS_C, TA_C));
  localparam int CNT_W = max_int(1, $clog2(MAX_C));

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             accept;
  logic             cap_en;

  asr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  asr_seq #(
    .RD_C (RD_C),
    .WS_C (WS_C),
    .WP_C (WP_C),
    .TA_C (TA_C),
    .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .cap_en    (cap_en),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe),
    .ready     (req_ready)
  );

  asr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cap_en     (cap_en),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R4
  AST_ADDR_HOLD_WE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R5
  AST_ADDR_HOLD_AFTER: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> ($stable(mem_addr) && $stable(mem_dq_out))); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(mem_addr)); // R6
  AST_RSP_ONE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> ($past(!mem_oe_n) && mem_oe_n)); // R8

endmodule

// File: tb/test_asr_ctrl.sv
`timescale 1ns/1ps
module test_asr_ctrl;
  localparam int PER = 5;  // timing parameter handed to the design
  localparam int RD  = (12 + PER - 1) / PER;
  localparam int PW  = (8 + PER - 1) / PER;
  localparam int SU0 = (7 + PER - 1) / PER - PW;
  localparam int SU  = (SU0 < 1) ? 1 : SU0;
  localparam int TA  = (6 + PER - 1) / PER;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [7:0]  mem_dq_in = 'z;
  logic [14:0] mem_addr;

  always #10 clk = ~clk;

  asr_ctrl #(.CLK_PERIOD_NS(PER)) i_asr_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  logic [7:0] mm [int];   // memory model
  logic [7:0] refm [int]; // reference contents

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_ref(input int a);
    return refm.exists(a) ? refm[a] : 8'h00;
  endfunction

  task automatic cmp_pins(input string tag, input bit ce, input bit we, input bit oe,
                          input bit doe, input bit rdy, input bit rv);
    chk(mem_ce_n === ce, {tag, " ce_n"}, mem_ce_n, ce);
    chk(mem_we_n === we, {tag, " we_n"}, mem_we_n, we);
    chk(mem_oe_n === oe, {tag, " oe_n"}, mem_oe_n, oe);
    chk(mem_dq_oe === doe, {tag, " dq_oe"}, mem_dq_oe, doe);
    chk(req_ready === rdy, {tag, " ready"}, req_ready, rdy);
    chk(rsp_valid === rv, {tag, " rsp_valid"}, rsp_valid, rv);
  endtask

  initial begin
    int kind = 0, k = 0, nops = 0;
    logic [14:0] cur_a = '0, p_addr = '0;
    logic [7:0]  cur_d = '0, p_dq = '0;
    bit prev_wr = 1'b0;
    logic [14:0] pool [8];
    pool = '{15'h0000, 15'h7FFF, 15'h0001, 15'h7FFE, 15'h1234, 15'h4000, 15'h2AAA, 15'h0555};
    void'($urandom(7));
    repeat (3) begin
      @(negedge clk);
      cmp_pins("R1 reset", 1, 1, 1, 0, 1, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    cmp_pins("R1 after reset", 1, 1, 1, 0, 1, 0);
    while (nops < 320) begin
      bit wr_now, drive;
      @(negedge clk);
      // memory model
      wr_now = !mem_ce_n && !mem_we_n;
      drive  = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (prev_wr && !wr_now) mm[int'(mem_addr)] = mem_dq_out;
      if (wr_now || prev_wr)
        chk(mem_addr == p_addr && mem_dq_out == p_dq, "R5 addr/data moved in write",
            {mem_addr, mem_dq_out}, {p_addr, p_dq});
      chk(!(drive && mem_dq_oe), "R4 bus contention", mem_dq_oe, 0);
      prev_wr = wr_now;
      p_addr  = mem_addr;
      p_dq    = mem_dq_out;
      mem_dq_in = drive ? (mm.exists(int'(mem_addr)) ? mm[int'(mem_addr)] : 8'h00) : 8'hzz;
      // expected pins
      if (kind == 0) cmp_pins("R10 idle", 1, 1, 1, 0, 1, 0);
      else if (kind == 1) begin
        if (k < RD) begin
          cmp_pins("R2 read strobe", 0, 1, 0, 0, 0, 0);
          chk(mem_addr == cur_a, "R2 read addr", mem_addr, cur_a);
        end else if (k == RD) begin
          cmp_pins("R8 read response", 1, 1, 1, 0, 0, 1);
          chk(rsp_rdata == cur_d, "R9 read data", rsp_rdata, cur_d);
        end else cmp_pins("R7 turnaround", 1, 1, 1, 0, 0, 0);
      end else begin
        if (k < SU) cmp_pins("R3 write setup", 0, 1, 1, 1, 0, 0);
        else if (k < SU + PW) cmp_pins("R4 write pulse", 0, 0, 1, 1, 0, 0);
        else cmp_pins("R3 write hold", 0, 1, 1, 1, 0, 0);
        chk(mem_addr == cur_a && mem_dq_out == cur_d, "R5 write pins",
            {mem_addr, mem_dq_out}, {cur_a, cur_d});
      end
      // advance and drive
      req_valid = 1'b0;
      if (kind == 0) begin
        bit issue, w;
        logic [14:0] a;
        logic [7:0] d;
        issue = 1'b1; w = 1'b0; a = '0; d = '0;
        case (nops)
          0: begin w = 1; a = 15'h0000; d = 8'hA5; end
          1: begin w = 1; a = 15'h7FFF; d = 8'h5A; end
          2: begin w = 0; a = 15'h0000; end
          3: begin w = 0; a = 15'h7FFF; end
          4: begin w = 1; a = 15'h1234; d = 8'h3C; end
          5: begin w = 0; a = 15'h1234; end
          6: begin w = 1; a = 15'h0000; d = 8'hFF; end
          7: begin w = 0; a = 15'h0000; end
          default: begin
            issue = ($urandom % 4) != 0;
            w = $urandom % 2;
            a = pool[$urandom % 8];
            d = 8'($urandom);
          end
        endcase
        if (issue) begin
          req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
          cur_a = a;
          if (w) begin refm[int'(a)] = d; cur_d = d; kind = 2; end
          else begin cur_d = rd_ref(int'(a)); kind = 1; end
          k = 0;
          nops++;
        end
      end else begin
        if ((kind == 1 && k == RD + TA - 1) || (kind == 2 && k == SU + PW)) kind = 0;
        else k++;
        // traffic while busy must be ignored (R6)
        req_valid = $urandom % 2;
        req_write = $urandom % 2;
        req_addr  = 15'($urandom);
        req_wdata = 8'($urandom);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (RD + TA + SU + PW + 2) @(negedge clk);
    cmp_pins("R6 final idle", 1, 1, 1, 0, 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule